// File: doc/BRIEF.md
# Receive Frame Parser with Packet Buffer

This block sits behind a demodulator that delivers one byte per valid symbol strobe, together with an energy sample for that byte. It hunts the byte stream for a run of zero-valued preamble bytes closed by a start-of-frame code. It then reads a length byte and stores everything that follows: the payload and the two received check bytes. These go into a 64-word by 16-bit buffer that the host reads through a simple registered read port.

While the payload streams in, the block runs a reflected CRC-16 over it. Starting on the clock after the start-of-frame code, it also averages the energy samples of the bytes that arrive within a fixed window of clock cycles. Only after the last check byte is stored and the average is ready does it publish the frame length, the CRC verdict and the link-quality value, and raise an interrupt. The interrupt stays high until the host clears it. A frame that starts while the interrupt is pending is ignored, so the stored packet and its status cannot be overwritten before the host has read them.

Top module: `rx_frame_parser`

## Requirements
- R1: Frame byte k (k counted from 0 at the first byte after the length byte) is written to buffer word k/2, in bits 7:0 when k is even and bits 15:8 when k is odd; `rd_data` shows word `rd_addr` one clock after the address is applied.
- R2: A start-of-frame is recognised only when the byte 0xA7 follows at least four consecutive valid 0x00 bytes; any other valid byte restarts the zero count.
- R3: The byte after the start-of-frame is the length L (payload plus two check bytes); L below 2 or above 127 abandons the frame with no interrupt and no status change.
- R4: After the length byte, exactly L-2 payload bytes and then the low and high check bytes are taken and all L bytes are stored.
- R5: The CRC uses polynomial x^16+x^12+x^5+1, initial value 0x0000, bits processed LSB first over the payload bytes only (reflected constant 0x8408); `rx_crc_ok` is 1 when the result equals {high check byte, low check byte}.
- R6: `rx_lq` is the floor of the mean of `sym_energy` over the valid bytes in the LQ_CYCLES clock cycles that follow the start-of-frame byte, and 0 when no valid byte falls in that window.
- R7: `irq` rises only after the last check byte is stored and the link-quality mean is ready; `rx_len`, `rx_crc_ok` and `rx_lq` change only at that moment.
- R8: Once raised, `irq` stays high until `irq_clr` is sampled high.
- R9: A frame whose start-of-frame arrives while `irq` is high is dropped: buffer contents and status stay as they were.
- R10: After reset, `irq`, `rx_len`, `rx_crc_ok` and `rx_lq` are all 0.
- R11: Bytes presented with `sym_valid` low are ignored by every part of the parser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Qualifies `sym_byte` and `sym_energy` for this cycle |
| sym_byte | input | 8 | Demodulated byte |
| sym_energy | input | 8 | Energy sample belonging to `sym_byte` |
| rd_addr | input | 6 | Host read word address |
| rd_data | output | 16 | Buffer word, one clock after `rd_addr` |
| rx_len | output | 7 | Length byte of the last published frame |
| rx_crc_ok | output | 1 | CRC verdict of the last published frame |
| rx_lq | output | 8 | Link-quality mean of the last published frame |
| irq | output | 1 | Packet-ready interrupt |
| irq_clr | input | 1 | Clears `irq` |

## Verification
The embedded assertions watch, on every cycle, that the interrupt holds until a clear, that no buffer write happens while it is pending, that the byte index never runs past the length, that the interrupt only rises out of the waiting state with a legal length published, and that the energy-byte count never outruns the window timer. Whether the right bytes land in the right lanes, whether the CRC verdict and link-quality mean are numerically right, and whether broken preambles, illegal lengths and frames during a pending interrupt really leave the buffer and status untouched can only be shown by the bench's frame scenarios, which compare port values against independently computed expectations.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    localparam int          ENERGY_W  = 8;
    localparam int          LEN_W     = 7;
    localparam int          LEN_MIN   = 2;
    localparam int          LEN_MAX   = 127;
    localparam int          PRE_ZEROS = 4;
    localparam logic [7:0]  SFD_CODE  = 8'hA7;
    localparam logic [15:0] CRC_REFL  = 16'h8408;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_LEN,
        ST_BODY,
        ST_WAIT
    } parse_st_e;

    typedef enum logic [1:0] {
        LQ_IDLE,
        LQ_WIN,
        LQ_DIV,
        LQ_DONE
    } lq_st_e;

    typedef struct packed {
        logic [LEN_W-1:0]    len;
        logic                crc_ok;
        logic [ENERGY_W-1:0] lq;
    } rx_status_t;

    // One byte of the reflected CRC-16, least significant bit first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxp_crc16.sv
module rxp_crc16
    import rxp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) crc_q <= '0;
        else if (en)      crc_q <= crc16_byte(crc_q, din);
    end

    assign crc = crc_q;

    // R5: the register only moves when a payload byte is fed or a frame starts
    a_r5_crc_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !clear) |=> $stable(crc));

    a_r5_crc_seed: assert property (@(posedge clk) disable iff (rst)
        clear |=> (crc == 16'h0000));

endmodule

// File: rtl/rxp_lq_meter.sv
module rxp_lq_meter
    import rxp_pkg::*;
#(
    parameter int LQ_CYCLES = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                abort,
    input  logic                smp_valid,
    input  logic [ENERGY_W-1:0] smp_energy,
    output logic                done,
    output logic [ENERGY_W-1:0] result
);

    localparam int CNT_W = $clog2(LQ_CYCLES + 1);
    localparam int SUM_W = ENERGY_W + CNT_W;
    localparam int IT_W  = $clog2(SUM_W + 1);

    lq_st_e              st;
    logic [CNT_W-1:0]    timer;
    logic [CNT_W-1:0]    n_smp;
    logic [SUM_W-1:0]    sum;
    logic [CNT_W-1:0]    rem;
    logic [ENERGY_W-1:0] quo;
    logic [IT_W-1:0]     it;

    logic [CNT_W:0]      rem_sh;
    logic                fits;

    always_comb begin
        rem_sh = {rem, sum[SUM_W-1]};
        fits   = (rem_sh >= {1'b0, n_smp});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= LQ_IDLE;
            timer <= '0;
            n_smp <= '0;
            sum   <= '0;
            rem   <= '0;
            quo   <= '0;
            it    <= '0;
        end else if (start) begin
            st    <= LQ_WIN;
            timer <= '0;
            n_smp <= '0;
            sum   <= '0;
        end else if (abort) begin
            st <= LQ_IDLE;
        end else begin
            unique case (st)
                LQ_WIN: begin
                    if (smp_valid) begin
                        sum   <= sum + SUM_W'(smp_energy);
                        n_smp <= n_smp + CNT_W'(1);
                    end
                    if (timer == CNT_W'(LQ_CYCLES - 1)) begin
                        st  <= LQ_DIV;
                        it  <= '0;
                        rem <= '0;
                        quo <= '0;
                    end else begin
                        timer <= timer + CNT_W'(1);
                    end
                end
                LQ_DIV: begin
                    sum <= sum << 1;
                    quo <= {quo[ENERGY_W-2:0], fits};
                    if (fits) rem <= CNT_W'(rem_sh - {1'b0, n_smp});
                    else      rem <= rem_sh[CNT_W-1:0];
                    if (it == IT_W'(SUM_W - 1)) st <= LQ_DONE;
                    else                        it <= it + IT_W'(1);
                end
                default: ;
            endcase
        end
    end

    assign done   = (st == LQ_DONE);
    assign result = (n_smp == '0) ? '0 : quo;

    // R6: bytes counted in the window never exceed the cycles elapsed in it
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        (st == LQ_WIN) |-> (n_smp <= timer));

    a_r6_restart_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

endmodule

// File: rtl/rxp_pkt_buf.sv
module rxp_pkt_buf #(
    parameter int WORDS  = 64,
    parameter int WORD_W = 16
) (
    input  logic                                          clk,
    input  logic                                          we,
    input  logic [$clog2(WORDS)+$clog2(WORD_W/8)-1:0]     widx,
    input  logic [7:0]                                    wbyte,
    input  logic [$clog2(WORDS)-1:0]                      raddr,
    output logic [WORD_W-1:0]                             rdata
);

    localparam int LANES  = WORD_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int ADDR_W = $clog2(WORDS);
    localparam int IDX_W  = ADDR_W + LANE_W;

    logic [ADDR_W-1:0] waddr;
    logic [LANE_W-1:0] wlane;

    assign waddr = widx[IDX_W-1:LANE_W];
    assign wlane = widx[LANE_W-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [WORDS];
        logic [7:0] rd_q;

        always_ff @(posedge clk) begin
            if (we && (wlane == LANE_W'(g))) mem[waddr] <= wbyte;
            rd_q <= mem[raddr];
        end

        assign rdata[g*8 +: 8] = rd_q;
    end

endmodule

// File: rtl/rxp_parse_fsm.sv
module rxp_parse_fsm
    import rxp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [7:0]          in_byte,
    input  logic                irq_clr,
    input  logic                lq_done,
    input  logic [ENERGY_W-1:0] lq_val,
    input  logic [15:0]         crc_val,
    output logic                crc_clear,
    output logic                crc_en,
    output logic                lq_start,
    output logic                lq_abort,
    output logic                buf_we,
    output logic [LEN_W-1:0]    buf_idx,
    output rx_status_t          status,
    output logic                irq
);

    parse_st_e        st;
    logic [2:0]       zc;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx_q;
    logic [15:0]      fcs_q;
    rx_status_t       stat_q;
    logic             irq_q;

    logic             sfd_hit;
    logic             len_ok;
    logic [LEN_W-1:0] pay_cnt;
    logic             body_byte;
    logic             commit;

    always_comb begin
        sfd_hit   = (st == ST_HUNT) && in_valid && (in_byte == SFD_CODE)
                    && (zc == 3'(PRE_ZEROS)) && !irq_q;
        len_ok    = (in_byte >= 8'(LEN_MIN)) && (in_byte <= 8'(LEN_MAX));
        pay_cnt   = len_q - LEN_W'(LEN_MIN);
        body_byte = (st == ST_BODY) && in_valid;
        commit    = (st == ST_WAIT) && lq_done;
        crc_clear = sfd_hit;
        lq_start  = sfd_hit;
        lq_abort  = (st == ST_LEN) && in_valid && !len_ok;
        crc_en    = body_byte && (idx_q < pay_cnt);
        buf_we    = body_byte;
        buf_idx   = idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_HUNT;
            zc     <= '0;
            len_q  <= '0;
            idx_q  <= '0;
            fcs_q  <= '0;
            stat_q <= '0;
        end else begin
            unique case (st)
                ST_HUNT: begin
                    if (in_valid) begin
                        if (in_byte == 8'h00)
                            zc <= (zc == 3'(PRE_ZEROS)) ? zc : zc + 3'd1;
                        else
                            zc <= '0;
                        if (sfd_hit) st <= ST_LEN;
                    end
                end
                ST_LEN: begin
                    if (in_valid) begin
                        if (len_ok) begin
                            len_q <= in_byte[LEN_W-1:0];
                            idx_q <= '0;
                            st    <= ST_BODY;
                        end else begin
                            st <= ST_HUNT;
                        end
                    end
                end
                ST_BODY: begin
                    if (in_valid) begin
                        idx_q <= idx_q + LEN_W'(1);
                        if (idx_q == pay_cnt) fcs_q[7:0] <= in_byte;
                        if (idx_q == len_q - LEN_W'(1)) begin
                            fcs_q[15:8] <= in_byte;
                            st          <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (lq_done) begin
                        stat_q.len    <= len_q;
                        stat_q.crc_ok <= (crc_val == fcs_q);
                        stat_q.lq     <= lq_val;
                        zc            <= '0;
                        st            <= ST_HUNT;
                    end
                end
                default: st <= ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          irq_q <= 1'b0;
        else if (commit)  irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    assign status = stat_q;
    assign irq    = irq_q;

    // R8: a raised interrupt is only dropped by the host clear
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    // R9: nothing is written into the buffer while a packet awaits the host
    a_r9_no_write_pending: assert property (@(posedge clk) disable iff (rst)
        irq |-> !buf_we);

    // R4: the byte index stays inside the announced frame
    a_r4_idx_in_frame: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BODY) |-> (idx_q < len_q));

    // R7: the interrupt only rises out of the waiting state
    a_r7_irq_after_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(st) == ST_WAIT));

    // R3: a published length is always a legal one
    a_r3_len_legal: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status.len >= LEN_W'(LEN_MIN)));

    // R1: writes never address past the last byte slot of the buffer
    a_r1_idx_range: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (buf_idx <= LEN_W'(LEN_MAX - 1)));

endmodule

// File: rtl/rx_frame_parser.sv
module rx_frame_parser
    import rxp_pkg::*;
#(
    parameter int LQ_CYCLES = 64,
    parameter int BUF_WORDS = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sym_valid,
    input  logic [7:0]                   sym_byte,
    input  logic [ENERGY_W-1:0]          sym_energy,
    input  logic [$clog2(BUF_WORDS)-1:0] rd_addr,
    output logic [15:0]                  rd_data,
    output logic [LEN_W-1:0]             rx_len,
    output logic                         rx_crc_ok,
    output logic [ENERGY_W-1:0]          rx_lq,
    output logic                         irq,
    input  logic                         irq_clr
);

    logic                crc_clear;
    logic                crc_en;
    logic [15:0]         crc_val;
    logic                lq_start;
    logic                lq_abort;
    logic                lq_done;
    logic [ENERGY_W-1:0] lq_val;
    logic                buf_we;
    logic [LEN_W-1:0]    buf_idx;
    rx_status_t          status;

    rxp_parse_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (sym_valid),
        .in_byte   (sym_byte),
        .irq_clr   (irq_clr),
        .lq_done   (lq_done),
        .lq_val    (lq_val),
        .crc_val   (crc_val),
        .crc_clear (crc_clear),
        .crc_en    (crc_en),
        .lq_start  (lq_start),
        .lq_abort  (lq_abort),
        .buf_we    (buf_we),
        .buf_idx   (buf_idx),
        .status    (status),
        .irq       (irq)
    );

    rxp_crc16 u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (crc_clear),
        .en    (crc_en),
        .din   (sym_byte),
        .crc   (crc_val)
    );

    rxp_lq_meter #(.LQ_CYCLES(LQ_CYCLES)) u_lq (
        .clk        (clk),
        .rst        (rst),
        .start      (lq_start),
        .abort      (lq_abort),
        .smp_valid  (sym_valid),
        .smp_energy (sym_energy),
        .done       (lq_done),
        .result     (lq_val)
    );

    rxp_pkt_buf #(.WORDS(BUF_WORDS), .WORD_W(16)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .widx  (buf_idx),
        .wbyte (sym_byte),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign rx_len    = status.len;
    assign rx_crc_ok = status.crc_ok;
    assign rx_lq     = status.lq;

    // R7: published status only changes on the cycle the interrupt rises
    a_r7_status_stable: assert property (@(posedge clk) disable iff (rst)
        !$rose(irq) |-> $stable(status));

endmodule

// File: tb/sim_rx_frame_parser.sv
module sim_rx_frame_parser;

    localparam int LQ_T = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic [7:0] sym_byte = 8'h00;
    logic [7:0] sym_energy = 8'h00;
    logic [5:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [6:0] rx_len;
    logic       rx_crc_ok;
    logic [7:0] rx_lq;
    logic       irq;
    logic       irq_clr = 1'b0;

    always #10 clk = ~clk;

    rx_frame_parser #(.LQ_CYCLES(LQ_T), .BUF_WORDS(64)) u0 (
        .clk        (clk),
        .rst        (rst),
        .sym_valid  (sym_valid),
        .sym_byte   (sym_byte),
        .sym_energy (sym_energy),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .rx_len     (rx_len),
        .rx_crc_ok  (rx_crc_ok),
        .rx_lq      (rx_lq),
        .irq        (irq),
        .irq_clr    (irq_clr)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    int cyc = 0;
    int sfd_cyc = 0;
    bit lq_arm = 0;
    int lq_sum = 0;
    int lq_n = 0;
    bit early_irq = 0;

    logic [7:0] cur_b [128];
    int         cur_len;
    bit         cur_ok;
    int         cur_lq;
    logic [7:0] acc_b [128];
    int         acc_len = 0;
    bit         acc_ok = 0;
    int         acc_lq = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic x;
                x = c[0] ^ cur_b[i][b];
                c = {1'b0, c[15:1]};
                if (x) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    task automatic put(input logic [7:0] b, input logic [7:0] e);
        @(negedge clk);
        early_irq  = early_irq | irq;
        sym_valid  = 1'b1;
        sym_byte   = b;
        sym_energy = e;
        cyc++;
        if (lq_arm && cyc > sfd_cyc && cyc <= sfd_cyc + LQ_T) begin
            lq_sum += e;
            lq_n++;
        end
    endtask

    // Idle cycles carry misleading bytes with the strobe low (R11).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            int k;
            @(negedge clk);
            k = $urandom % 3;
            sym_valid  = 1'b0;
            sym_byte   = (k == 0) ? 8'h00 : (k == 1) ? 8'hA7 : 8'($urandom);
            sym_energy = 8'($urandom);
            cyc++;
        end
    endtask

    task automatic send_frame(input int len, input bit bad_fcs, input int max_gap,
                              input int nz, input int lead_gap);
        logic [15:0] c;
        int pay;
        pay = len - 2;
        early_irq = 0;
        lq_arm = 0;
        for (int i = 0; i < int'($urandom % 3); i++) put(8'h30 | 8'($urandom % 16), 8'h0);
        for (int i = 0; i < nz; i++) begin
            put(8'h00, 8'h0);
            idle($urandom % (max_gap + 1));
        end
        lq_sum = 0;
        lq_n = 0;
        put(8'hA7, 8'h0);
        sfd_cyc = cyc;
        lq_arm = 1;
        idle(lead_gap);
        put(8'(len), 8'($urandom));
        for (int i = 0; i < pay; i++) cur_b[i] = 8'($urandom);
        c = ref_crc(pay);
        if (bad_fcs) c = c ^ 16'h0100;
        cur_b[pay]     = c[7:0];
        cur_b[pay + 1] = c[15:8];
        for (int i = 0; i < len; i++) begin
            idle($urandom % (max_gap + 1));
            put(cur_b[i], 8'($urandom));
        end
        cur_len = len;
        cur_ok  = !bad_fcs;
        cur_lq  = (lq_n == 0) ? 0 : lq_sum / lq_n;
        lq_arm  = 0;
    endtask

    task automatic wait_irq(output bit got);
        got = 0;
        for (int i = 0; i < 400 && !got; i++) begin
            idle(1);
            if (irq) got = 1;
        end
    endtask

    task automatic read_word(input int a, output logic [15:0] d);
        @(negedge clk);
        rd_addr = 6'(a);
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic check_status(input string tag);
        check(rx_len == 7'(acc_len), {"R3 R4 ", tag}, "length", rx_len, acc_len);
        check(rx_crc_ok == acc_ok, {"R5 ", tag}, "crc_ok", rx_crc_ok, acc_ok);
        check(rx_lq == 8'(acc_lq), {"R6 ", tag}, "link quality", rx_lq, acc_lq);
    endtask

    task automatic check_buffer(input string tag);
        for (int w = 0; w < (acc_len + 1) / 2; w++) begin
            logic [15:0] d, e, m;
            read_word(w, d);
            e = {acc_b[2*w+1], acc_b[2*w]};
            m = (2*w + 1 < acc_len) ? 16'hFFFF : 16'h00FF;
            check((d & m) == (e & m), {"R1 R4 ", tag}, $sformatf("word %0d", w),
                  int'(d & m), int'(e & m));
        end
    endtask

    task automatic accept(input string tag);
        bit got;
        wait_irq(got);
        check(got, {"R7 ", tag}, "irq after frame", got, 1);
        check(!early_irq, {"R7 ", tag}, "irq before last byte", early_irq, 0);
        if (got) begin
            acc_len = cur_len;
            acc_ok  = cur_ok;
            acc_lq  = cur_lq;
            for (int i = 0; i < 128; i++) acc_b[i] = cur_b[i];
            check_status(tag);
            check_buffer(tag);
        end
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check(irq == 1'b0, "R8", "irq after clear", irq, 0);
    endtask

    task automatic expect_no_frame(input string req, input string tag);
        idle(LQ_T + 60);
        check(irq == 1'b0, req, {tag, " irq"}, irq, 0);
        check(rx_len == 7'(acc_len) && rx_crc_ok == acc_ok && rx_lq == 8'(acc_lq),
              req, {tag, " status"}, rx_len, acc_len);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(irq == 0, "R10", "irq", irq, 0);
        check(rx_len == 0, "R10", "length", rx_len, 0);
        check(rx_crc_ok == 0, "R10", "crc_ok", rx_crc_ok, 0);
        check(rx_lq == 0, "R10", "link quality", rx_lq, 0);

        // Shortest legal frame: no payload, check bytes 0x0000.
        send_frame(2, 0, 0, 4, 0);
        accept("len2");
        clear_irq();

        // Longest frame fills all 64 words.
        send_frame(127, 0, 0, 5, 0);
        accept("len127");
        clear_irq();

        // No byte inside the link-quality window gives 0 (R6).
        send_frame(6, 0, 0, 4, LQ_T + 3);
        accept("empty window");
        check(rx_lq == 0, "R6", "empty window mean", rx_lq, 0);
        clear_irq();

        // Wrong check bytes.
        send_frame(9, 1, 2, 4, 0);
        accept("bad fcs");
        clear_irq();

        // Random frames with gaps full of strobe-low bytes (R11).
        for (int f = 0; f < 24; f++) begin
            int len;
            len = ($urandom % 4 == 0) ? 2 + int'($urandom % 6) : 2 + int'($urandom % 126);
            send_frame(len, ($urandom % 3) == 0, $urandom % 4, 4 + int'($urandom % 3), 0);
            accept($sformatf("R11 random %0d", f));
            clear_irq();
        end

        // Three zeros only, and a zero run broken by another byte (R2).
        put(8'h00, 0); put(8'h00, 0); put(8'h00, 0); put(8'hA7, 0);
        put(8'd8, 0);
        for (int i = 0; i < 8; i++) put(8'h55, 0);
        expect_no_frame("R2", "three zeros");
        put(8'h00, 0); put(8'h00, 0); put(8'h11, 0); put(8'h00, 0); put(8'h00, 0);
        put(8'hA7, 0); put(8'd4, 0);
        for (int i = 0; i < 4; i++) put(8'h55, 0);
        expect_no_frame("R2", "broken run");

        // Illegal length bytes (R3).
        foreach (cur_len_vals[i]) begin
            for (int z = 0; z < 4; z++) put(8'h00, 0);
            put(8'hA7, 0);
            put(cur_len_vals[i], 0);
            for (int k = 0; k < 6; k++) put(8'h55, 0);
            expect_no_frame("R3", $sformatf("length %0d", cur_len_vals[i]));
        end

        // Frame arriving while the interrupt is pending (R8, R9).
        send_frame(12, 0, 1, 4, 0);
        accept("before drop");
        send_frame(40, 1, 0, 4, 0);
        idle(LQ_T + 60);
        check(irq == 1'b1, "R8", "irq held while pending", irq, 1);
        check(rx_len == 7'(acc_len) && rx_crc_ok == acc_ok && rx_lq == 8'(acc_lq),
              "R9", "status after dropped frame", rx_len, acc_len);
        check_buffer("R9 dropped frame");
        clear_irq();

        // Parser recovers after the drop.
        send_frame(17, 0, 1, 6, 0);
        accept("after drop");
        clear_irq();

        finish_run();
    end

    logic [7:0] cur_len_vals [4] = '{8'd0, 8'd1, 8'd128, 8'd255};

endmodule